// File: doc/BRIEF.md
# Framebuffer Aperture Pixel Remapper

This block sits between a host access port and the framebuffer memory port. It serves two host windows. Each window has its own formatting setting, made of a byte-lane swap mode and an optional packed single-buffer view. Every host word access is turned into one or two memory word accesses with byte enables. For reads, the returned memory words are gathered into one host word.

In the dual-buffer 16-bit layout, each 32-bit memory word holds one front-buffer pixel in bits [15:0] and one back-buffer pixel in bits [31:16]. Pixels of the same buffer are therefore interleaved with pixels of the other buffer. A window in packed view shows only one buffer, as contiguous 16-bit pixels, two to a host word. Writes through such a window touch only the halfwords of the chosen buffer.

Both the host request port and the host read-response port use valid/ready. A request stays pending while `hreq_ready` is low. The block accepts a new request only when the previous transaction has fully finished: a write is finished when its last memory write is accepted, and a read is finished when its response is taken. Read data is presented on `hrsp_data` with `hrsp_valid` and is held until `hrsp_ready` is seen. On the memory side, `mem_valid` is held with stable fields until `mem_ready` is seen. At most one memory read is outstanding, and its data returns on `mem_rvalid` in a later cycle. Memory byte enables are meaningful only on writes.

Top module: `fb_aperture_remap`

## Requirements
- R1: Window w (0 or 1), selected by `hreq_win`, uses `cfg_pack[w]`, `cfg_back[w]` and `cfg_swap[2w+1:2w]`. These settings are sampled when the request is accepted. The two windows never influence each other.
- R2: Swap mode encoding, for a word with bytes B3 B2 B1 B0 (B0 = bits [7:0]):
  - 0 leaves the word unchanged.
  - 1 gives B2 B3 B0 B1 (bytes exchanged within each halfword).
  - 2 gives B1 B0 B3 B2 (the two halfwords exchanged).
  - 3 gives B0 B1 B2 B3 (all bytes reversed).
  Byte enables move with their bytes.
- R3: When `cfg_pack` is 0 (direct view), host word N maps to memory word N. The write data and byte enables are the swapped host values, sent in a single memory access. A read returns the swapped memory word.
- R4: When `cfg_pack` is 1 (packed view), host word N covers memory words 2N and 2N+1. Host bits [15:0] belong to word 2N and host bits [31:16] to word 2N+1. The selected halfword is [15:0] when `cfg_back` is 0 (front) and [31:16] when `cfg_back` is 1 (back).
- R5: A packed-view write issues memory writes whose byte enables cover only the selected buffer's halfword. The other buffer's pixels in those words keep their values.
- R6: A packed-view read issues two memory reads, to word 2N and then word 2N+1. It returns the combined word only after both complete. The swap is applied after the combination.
- R7: On writes, the swap is applied to the host data and byte enables before the packed remap.
- R8: No memory write is issued for a half, or for a whole host write, whose byte enables after swapping are all clear. A host write with no enables set causes no memory access.
- R9: `hreq_ready` is high only when no transaction is in progress, so transactions never overlap.
- R10: While `hrsp_valid` is high and `hrsp_ready` is low, `hrsp_valid` stays high and `hrsp_data` stays unchanged.
- R11: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_write`, `mem_addr`, `mem_wdata` and `mem_be` stay unchanged.
- R12: When memory is always ready and read data returns one cycle after the request is accepted, `hrsp_valid` rises 3 cycles after a direct-view read is accepted and 5 cycles after a packed-view read is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pack | input | NUM_WIN | Per-window packed single-buffer view enable |
| cfg_back | input | NUM_WIN | Per-window buffer select in packed view (1 = back) |
| cfg_swap | input | 2*NUM_WIN | Per-window swap mode, 2 bits per window |
| hreq_valid | input | 1 | Host request valid |
| hreq_ready | output | 1 | Host request ready |
| hreq_win | input | WIN_W | Window index of the request |
| hreq_write | input | 1 | 1 = write, 0 = read |
| hreq_addr | input | ADDR_W | Host word address within the window |
| hreq_wdata | input | 32 | Host write data |
| hreq_be | input | 4 | Host byte enables (writes) |
| hrsp_valid | output | 1 | Read response valid |
| hrsp_ready | input | 1 | Read response ready |
| hrsp_data | output | 32 | Read response data |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request ready |
| mem_write | output | 1 | Memory request is a write |
| mem_addr | output | ADDR_W+1 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_be | output | 4 | Memory byte enables |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | 32 | Memory read data |

## Verification
A request is accepted at a clock edge. The first memory access appears in the cycle after that edge, and the bench's memory model returns read data one cycle after each accepted read. A read response is therefore due on the third falling edge after acceptance in direct view and on the fifth in packed view. The read task counts falling edges until `hrsp_valid` and compares that count against those figures. Memory contents and access counters are inspected only after the write task has seen `hreq_ready` return. The back-pressure scenario samples the response on every falling edge while it is held. That scenario throttles `mem_ready` and omits the latency check.

// File: rtl/fbr_pkg.sv
package fbr_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = WORD_W / 2;
  localparam int LANES  = WORD_W / 8;

  typedef enum logic [1:0] {
    SW_NONE    = 2'd0,
    SW_IN_HALF = 2'd1,
    SW_HALVES  = 2'd2,
    SW_REVERSE = 2'd3
  } swap_e;

  typedef struct packed {
    logic       pack;
    logic       back;
    logic [1:0] swap;
  } win_cfg_t;

  // lane index mapping: destination lane d takes source lane src_lane(d, m)
  function automatic int src_lane(input int d, input logic [1:0] m);
    case (swap_e'(m))
      SW_IN_HALF: return d ^ 1;
      SW_HALVES:  return d ^ 2;
      SW_REVERSE: return LANES - 1 - d;
      default:    return d;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] swap_word(input logic [WORD_W-1:0] d, input logic [1:0] m);
    logic [WORD_W-1:0] r;
    for (int k = 0; k < LANES; k++) r[8*k +: 8] = d[8*src_lane(k, m) +: 8];
    return r;
  endfunction

  function automatic logic [LANES-1:0] swap_be(input logic [LANES-1:0] b, input logic [1:0] m);
    logic [LANES-1:0] r;
    for (int k = 0; k < LANES; k++) r[k] = b[src_lane(k, m)];
    return r;
  endfunction
endpackage

// File: rtl/fbr_cfg_sel.sv
module fbr_cfg_sel
  import fbr_pkg::*;
#(
  parameter int NUM_WIN = 2,
  parameter int WIN_W   = 1
) (
  input  logic [NUM_WIN-1:0]   cfg_pack,
  input  logic [NUM_WIN-1:0]   cfg_back,
  input  logic [2*NUM_WIN-1:0] cfg_swap,
  input  logic [WIN_W-1:0]     sel,
  output win_cfg_t             cfg
);
  win_cfg_t tbl [NUM_WIN];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    assign tbl[w] = '{pack: cfg_pack[w], back: cfg_back[w], swap: cfg_swap[2*w +: 2]};
  end

  always_comb begin
    cfg = '0;
    for (int w = 0; w < NUM_WIN; w++)
      if (int'(sel) == w) cfg = tbl[w];
  end
endmodule

// File: rtl/fbr_beat_map.sv
module fbr_beat_map
  import fbr_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  win_cfg_t            cfg,
  input  logic                beat,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [WORD_W-1:0]   wdata,
  input  logic [LANES-1:0]    be,
  input  logic [WORD_W-1:0]   rd0,
  input  logic [WORD_W-1:0]   rd1,
  output logic [ADDR_W:0]     maddr,
  output logic [WORD_W-1:0]   mdata,
  output logic [LANES-1:0]    mbe,
  output logic [WORD_W-1:0]   host_rdata
);
  localparam int HL = LANES / 2;

  logic [HALF_W-1:0] half_d;
  logic [HL-1:0]     half_be;
  logic [WORD_W-1:0] gathered;

  always_comb begin
    half_d  = beat ? wdata[WORD_W-1:HALF_W] : wdata[HALF_W-1:0];
    half_be = beat ? be[LANES-1:HL] : be[HL-1:0];
    if (!cfg.pack) begin
      maddr = {1'b0, addr};
      mdata = wdata;
      mbe   = be;
    end else begin
      maddr = {addr, beat};
      if (cfg.back) begin
        mdata = {half_d, {HALF_W{1'b0}}};
        mbe   = {half_be, {HL{1'b0}}};
      end else begin
        mdata = {{HALF_W{1'b0}}, half_d};
        mbe   = {{HL{1'b0}}, half_be};
      end
    end
  end

  always_comb begin
    if (!cfg.pack)     gathered = rd0;
    else if (cfg.back) gathered = {rd1[WORD_W-1:HALF_W], rd0[WORD_W-1:HALF_W]};
    else               gathered = {rd1[HALF_W-1:0], rd0[HALF_W-1:0]};
    host_rdata = swap_word(gathered, cfg.swap);
  end
endmodule

// File: rtl/fbr_ctrl.sv
module fbr_ctrl
  import fbr_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hreq_valid,
  output logic              hreq_ready,
  input  logic              hreq_write,
  input  logic [ADDR_W-1:0] hreq_addr,
  input  logic [WORD_W-1:0] hreq_wdata,
  input  logic [LANES-1:0]  hreq_be,
  input  win_cfg_t          cfg_in,
  output logic              hrsp_valid,
  input  logic              hrsp_ready,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic [LANES-1:0]  beat_be,
  output win_cfg_t          lat_cfg,
  output logic [ADDR_W-1:0] lat_addr,
  output logic [WORD_W-1:0] lat_data,
  output logic [LANES-1:0]  lat_be,
  output logic              beat,
  output logic [WORD_W-1:0] rd_word0,
  output logic [WORD_W-1:0] rd_word1
);
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_RESP} state_e;

  state_e state;
  logic   lat_write;
  logic   last_beat, skip;

  assign last_beat  = !lat_cfg.pack || beat;
  assign skip       = lat_write && (beat_be == '0);
  assign mem_valid  = (state == ST_REQ) && !skip;
  assign mem_write  = lat_write;
  assign hreq_ready = (state == ST_IDLE);
  assign hrsp_valid = (state == ST_RESP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      beat      <= 1'b0;
      lat_write <= 1'b0;
      lat_cfg   <= '0;
      lat_addr  <= '0;
      lat_data  <= '0;
      lat_be    <= '0;
      rd_word0  <= '0;
      rd_word1  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (hreq_valid) begin
          lat_write <= hreq_write;
          lat_cfg   <= cfg_in;
          lat_addr  <= hreq_addr;
          lat_data  <= swap_word(hreq_wdata, cfg_in.swap);
          lat_be    <= swap_be(hreq_be, cfg_in.swap);
          beat      <= 1'b0;
          state     <= ST_REQ;
        end
        ST_REQ: if (skip || (mem_valid && mem_ready)) begin
          if (!lat_write)     state <= ST_WAIT;
          else if (last_beat) state <= ST_IDLE;
          else                beat  <= 1'b1;
        end
        ST_WAIT: if (mem_rvalid) begin
          if (beat) rd_word1 <= mem_rdata;
          else      rd_word0 <= mem_rdata;
          if (last_beat) state <= ST_RESP;
          else begin
            beat  <= 1'b1;
            state <= ST_REQ;
          end
        end
        ST_RESP: if (hrsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // checker: memory reads issued for the transaction being answered
  logic [1:0] rd_issued;
  always_ff @(posedge clk) begin
    if (!rst_n) rd_issued <= '0;
    else if (hreq_valid && hreq_ready) rd_issued <= '0;
    else if (mem_valid && mem_ready && !mem_write) rd_issued <= rd_issued + 2'd1;
  end

  // R6 / R3: one read in direct view, two in packed view, before the response
  a_r6_read_pairs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hrsp_valid) |-> rd_issued == (lat_cfg.pack ? 2'd2 : 2'd1));

  // R9: an accepted request closes the request port in the next cycle
  a_r9_single_txn: assert property (@(posedge clk) disable iff (!rst_n)
    (hreq_valid && hreq_ready) |=> !hreq_ready);
endmodule

// File: rtl/fb_aperture_remap.sv
module fb_aperture_remap
  import fbr_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int NUM_WIN = 2,
  parameter int WIN_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_WIN-1:0]   cfg_pack,
  input  logic [NUM_WIN-1:0]   cfg_back,
  input  logic [2*NUM_WIN-1:0] cfg_swap,
  input  logic                 hreq_valid,
  output logic                 hreq_ready,
  input  logic [WIN_W-1:0]     hreq_win,
  input  logic                 hreq_write,
  input  logic [ADDR_W-1:0]    hreq_addr,
  input  logic [31:0]          hreq_wdata,
  input  logic [3:0]           hreq_be,
  output logic                 hrsp_valid,
  input  logic                 hrsp_ready,
  output logic [31:0]          hrsp_data,
  output logic                 mem_valid,
  input  logic                 mem_ready,
  output logic                 mem_write,
  output logic [ADDR_W:0]      mem_addr,
  output logic [31:0]          mem_wdata,
  output logic [3:0]           mem_be,
  input  logic                 mem_rvalid,
  input  logic [31:0]          mem_rdata
);
  win_cfg_t          sel_cfg, lat_cfg;
  logic [ADDR_W-1:0] lat_addr;
  logic [31:0]       lat_data, rd_word0, rd_word1;
  logic [3:0]        lat_be;
  logic              beat;

  fbr_cfg_sel #(.NUM_WIN(NUM_WIN), .WIN_W(WIN_W)) u_sel (
    .cfg_pack (cfg_pack),
    .cfg_back (cfg_back),
    .cfg_swap (cfg_swap),
    .sel      (hreq_win),
    .cfg      (sel_cfg)
  );

  fbr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .hreq_valid (hreq_valid),
    .hreq_ready (hreq_ready),
    .hreq_write (hreq_write),
    .hreq_addr  (hreq_addr),
    .hreq_wdata (hreq_wdata),
    .hreq_be    (hreq_be),
    .cfg_in     (sel_cfg),
    .hrsp_valid (hrsp_valid),
    .hrsp_ready (hrsp_ready),
    .mem_valid  (mem_valid),
    .mem_ready  (mem_ready),
    .mem_write  (mem_write),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .beat_be    (mem_be),
    .lat_cfg    (lat_cfg),
    .lat_addr   (lat_addr),
    .lat_data   (lat_data),
    .lat_be     (lat_be),
    .beat       (beat),
    .rd_word0   (rd_word0),
    .rd_word1   (rd_word1)
  );

  fbr_beat_map #(.ADDR_W(ADDR_W)) u_map (
    .cfg        (lat_cfg),
    .beat       (beat),
    .addr       (lat_addr),
    .wdata      (lat_data),
    .be         (lat_be),
    .rd0        (rd_word0),
    .rd1        (rd_word1),
    .maddr      (mem_addr),
    .mdata      (mem_wdata),
    .mbe        (mem_be),
    .host_rdata (hrsp_data)
  );

  // R11: memory request fields frozen while stalled
  a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && mem_write == $past(mem_write) &&
      $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_be)));

  // R10: response held until taken
  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (hrsp_valid && !hrsp_ready) |=> (hrsp_valid && $stable(hrsp_data)));

  // R8: an issued write always carries at least one enable
  a_r8_no_empty_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_write) |-> (mem_be != 4'b0000));

  // R5: packed-view writes stay inside the chosen buffer's halfword
  a_r5_half_only: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_write && lat_cfg.pack) |->
      (lat_cfg.back ? (mem_be[1:0] == 2'b00) : (mem_be[3:2] == 2'b00)));
endmodule

// File: tb/sim_fb_aperture_remap.sv
module sim_fb_aperture_remap;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_pack = '0, cfg_back = '0;
  logic [3:0]  cfg_swap = '0;
  logic        hreq_valid = 1'b0, hreq_write = 1'b0, hrsp_ready = 1'b0;
  logic [0:0]  hreq_win = '0;
  logic [19:0] hreq_addr = '0;
  logic [31:0] hreq_wdata = '0;
  logic [3:0]  hreq_be = '0;
  logic        hreq_ready, hrsp_valid, mem_valid, mem_write;
  logic [31:0] hrsp_data, mem_wdata;
  logic [20:0] mem_addr;
  logic [3:0]  mem_be;
  logic        mem_ready, mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  int checks = 0, errors = 0;
  int wr_cnt = 0, rd_cnt = 0;
  logic stall_en = 1'b0, stall_tick = 1'b0;
  logic [31:0] fbmem [64];

  always #2.5 clk = ~clk;

  assign mem_ready = !stall_en || stall_tick;

  fb_aperture_remap u0 (
    .clk(clk), .rst_n(rst_n), .cfg_pack(cfg_pack), .cfg_back(cfg_back), .cfg_swap(cfg_swap),
    .hreq_valid(hreq_valid), .hreq_ready(hreq_ready), .hreq_win(hreq_win), .hreq_write(hreq_write),
    .hreq_addr(hreq_addr), .hreq_wdata(hreq_wdata), .hreq_be(hreq_be),
    .hrsp_valid(hrsp_valid), .hrsp_ready(hrsp_ready), .hrsp_data(hrsp_data),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  // memory model: read data returns one cycle after acceptance
  always @(posedge clk) begin
    stall_tick <= ~stall_tick;
    mem_rvalid <= 1'b0;
    if (rst_n && mem_valid && mem_ready) begin
      if (mem_write) begin
        for (int k = 0; k < 4; k++)
          if (mem_be[k]) fbmem[mem_addr[5:0]][8*k +: 8] <= mem_wdata[8*k +: 8];
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rdata  <= fbmem[mem_addr[5:0]];
        mem_rvalid <= 1'b1;
        rd_cnt     <= rd_cnt + 1;
      end
    end
  end

  function automatic logic [31:0] exp_swap(input logic [31:0] d, input int m);
    case (m)
      1: return {d[23:16], d[31:24], d[7:0], d[15:8]};
      2: return {d[15:0], d[31:16]};
      3: return {d[7:0], d[15:8], d[23:16], d[31:24]};
      default: return d;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_win(input int w, input bit pk, input bit bk, input int sw);
    cfg_pack[w] = pk;
    cfg_back[w] = bk;
    cfg_swap[2*w +: 2] = sw[1:0];
  endtask

  task automatic host_write(input int w, input int a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    hreq_valid = 1'b1; hreq_write = 1'b1; hreq_win = w[0:0];
    hreq_addr = a[19:0]; hreq_wdata = d; hreq_be = be;
    while (!hreq_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    hreq_valid = 1'b0;
    while (!hreq_ready) @(negedge clk);
  endtask

  task automatic host_read(input int w, input int a, output logic [31:0] d, output int lat);
    @(negedge clk);
    hreq_valid = 1'b1; hreq_write = 1'b0; hreq_win = w[0:0]; hreq_addr = a[19:0];
    while (!hreq_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    hreq_valid = 1'b0;
    lat = 1;
    while (!hrsp_valid) begin @(negedge clk); lat++; end
    d = hrsp_data;
    hrsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    hrsp_ready = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(hreq_ready === 1'b1, "R9 reset ready", {31'b0, hreq_ready}, 32'd1);
    check(mem_valid === 1'b0 && hrsp_valid === 1'b0, "R9 reset idle outputs",
          {30'b0, mem_valid, hrsp_valid}, 32'd0);
  endtask

  task automatic t_direct_swaps();
    logic [31:0] d; int lat;
    for (int m = 0; m < 4; m++) begin
      set_win(0, 0, 0, m);
      host_write(0, 3, 32'h11223344, 4'hF);
      check(fbmem[3] === exp_swap(32'h11223344, m), "R2 R3 direct write swap", fbmem[3], exp_swap(32'h11223344, m));
      host_read(0, 3, d, lat);
      check(d === 32'h11223344, "R2 R3 direct read swap", d, 32'h11223344);
      check(lat == 3, "R12 direct read latency", lat, 3);
    end
    fbmem[5] = 32'hAAAAAAAA;
    set_win(0, 0, 0, 3);
    host_write(0, 5, 32'h11223344, 4'b0001);
    check(fbmem[5] === 32'h44AAAAAA, "R2 enables follow bytes", fbmem[5], 32'h44AAAAAA);
  endtask

  task automatic t_packed_write();
    int w0;
    fbmem[8] = 32'hAAAABBBB; fbmem[9] = 32'hCCCCDDDD;
    set_win(1, 1, 0, 0);
    w0 = wr_cnt;
    host_write(1, 4, 32'h12345678, 4'hF);
    check(fbmem[8] === 32'hAAAA5678, "R4 R5 front low word", fbmem[8], 32'hAAAA5678);
    check(fbmem[9] === 32'hCCCC1234, "R4 R5 front high word", fbmem[9], 32'hCCCC1234);
    check(wr_cnt - w0 == 2, "R5 two writes", wr_cnt - w0, 2);
    fbmem[10] = 32'hAAAABBBB; fbmem[11] = 32'hCCCCDDDD;
    set_win(1, 1, 1, 0);
    host_write(1, 5, 32'h12345678, 4'hF);
    check(fbmem[10] === 32'h5678BBBB, "R4 R5 back low word", fbmem[10], 32'h5678BBBB);
    check(fbmem[11] === 32'h1234DDDD, "R4 R5 back high word", fbmem[11], 32'h1234DDDD);
  endtask

  task automatic t_packed_read();
    logic [31:0] d; int lat, r0;
    fbmem[12] = 32'h1111AAAA; fbmem[13] = 32'h2222BBBB;
    set_win(1, 1, 0, 0);
    r0 = rd_cnt;
    host_read(1, 6, d, lat);
    check(d === 32'hBBBBAAAA, "R6 front gather", d, 32'hBBBBAAAA);
    check(lat == 5, "R12 packed read latency", lat, 5);
    check(rd_cnt - r0 == 2, "R6 two reads", rd_cnt - r0, 2);
    set_win(1, 1, 1, 1);
    host_read(1, 6, d, lat);
    check(d === exp_swap(32'h22221111, 1), "R6 back gather then swap", d, exp_swap(32'h22221111, 1));
  endtask

  task automatic t_swap_order();
    logic [31:0] d; int lat, w0;
    fbmem[14] = 32'hFFFF0000; fbmem[15] = 32'hEEEE0000;
    set_win(1, 1, 0, 2);
    host_write(1, 7, 32'h12345678, 4'hF);
    check(fbmem[14] === 32'hFFFF1234, "R7 swap before remap low", fbmem[14], 32'hFFFF1234);
    check(fbmem[15] === 32'hEEEE5678, "R7 swap before remap high", fbmem[15], 32'hEEEE5678);
    host_read(1, 7, d, lat);
    check(d === 32'h12345678, "R6 R7 round trip", d, 32'h12345678);
    w0 = wr_cnt;
    host_write(1, 7, 32'h0000ABCD, 4'b0011);
    check(wr_cnt - w0 == 1, "R8 R7 half skipped", wr_cnt - w0, 1);
    check(fbmem[14] === 32'hFFFF1234, "R8 skipped half untouched", fbmem[14], 32'hFFFF1234);
    check(fbmem[15] === 32'hEEEEABCD, "R7 enables swapped", fbmem[15], 32'hEEEEABCD);
  endtask

  task automatic t_zero_be();
    int w0, r0;
    fbmem[20] = 32'h5A5A5A5A;
    set_win(0, 0, 0, 0);
    w0 = wr_cnt; r0 = rd_cnt;
    host_write(0, 20, 32'h0, 4'b0000);
    set_win(1, 1, 1, 3);
    host_write(1, 10, 32'h0, 4'b0000);
    check(wr_cnt == w0 && rd_cnt == r0, "R8 no access", wr_cnt - w0, 0);
    check(fbmem[20] === 32'h5A5A5A5A, "R8 memory unchanged", fbmem[20], 32'h5A5A5A5A);
  endtask

  task automatic t_windows();
    logic [31:0] d; int lat;
    fbmem[30] = 32'h0; fbmem[31] = 32'h0;
    set_win(0, 0, 0, 0);
    set_win(1, 1, 1, 0);
    host_write(0, 30, 32'hCAFEF00D, 4'hF);
    check(fbmem[30] === 32'hCAFEF00D, "R1 window0 direct", fbmem[30], 32'hCAFEF00D);
    host_read(1, 15, d, lat);
    check(d === 32'h0000CAFE, "R1 window1 packed back", d, 32'h0000CAFE);
    host_read(0, 30, d, lat);
    check(d === 32'hCAFEF00D, "R1 window0 unaffected", d, 32'hCAFEF00D);
  endtask

  task automatic t_backpressure();
    logic [31:0] held;
    fbmem[40] = 32'h0BAD0001; fbmem[41] = 32'h0BAD0002;
    set_win(0, 1, 0, 0);
    stall_en = 1'b1;
    @(negedge clk);
    hreq_valid = 1'b1; hreq_write = 1'b0; hreq_win = 1'b0; hreq_addr = 20'd20;
    while (!hreq_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    hreq_valid = 1'b0;
    check(hreq_ready === 1'b0, "R9 busy after accept", {31'b0, hreq_ready}, 32'd0);
    while (!hrsp_valid) @(negedge clk);
    held = hrsp_data;
    check(held === 32'h00020001, "R6 stalled memory gather", held, 32'h00020001);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(hrsp_valid === 1'b1 && hrsp_data === held, "R10 response held", hrsp_data, held);
    end
    hrsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    hrsp_ready = 1'b0;
    check(hrsp_valid === 1'b0 && hreq_ready === 1'b1, "R10 released", {30'b0, hrsp_valid, hreq_ready}, 32'd1);
    stall_en = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) fbmem[i] = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_direct_swaps();
    t_packed_write();
    t_packed_read();
    t_swap_order();
    t_zero_be();
    t_windows();
    t_backpressure();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule